// File: doc/BRIEF.md
# Interrupt Request Conditioning and Gating Unit

This unit sits between the peripherals of a small 8-bit controller and its interrupt sequencer. It takes raw request lines from a peripheral serial event, a bank of general-purpose port pins, two timers, an A/D converter and a UART. Each line is qualified by its own enable. The qualified lines are merged into four source request lines, one non-maskable request and a wake-up signal for the low-power states. A write-only option register on a plain bus write port picks the sensing mode of source 1, the active edge of source 2, and a global gate.

Edge-sensed inputs pass through a synchronizer and a rising-edge detector into a pending latch. The latch holds the request until the sequencer pulses the matching acknowledge. Sources 3 and 4 carry flags that their peripherals hold, so they pass through after masking with no latch. The global gate blocks every source but the non-maskable one. While the gate is off, the non-maskable request still reaches the sequencer, but it cannot raise the wake-up output.

All pins are plain control and status signals. The block takes part in no stream transfer, so no port has a valid/ready pair.

Top module: `irq_cond_top`

## Requirements
- R1: After reset the option register holds zero. `src_req`, `nmi_req` and `wake` are all low.
- R2: A write with `wr_en` high and `wr_addr` equal to C8h loads the register on that clock edge. From then on, data bit 6 is the level-mode select of source 1, bit 5 is the rising-edge select of source 2, and bit 4 is the global gate. Writes to any other address change nothing. Bits 7 and 3..0 have no effect.
- R3: While the global gate (bit 4) is 0, `src_req` is all zero and `wake` is low. Pending latches keep their state, and their requests reappear once the gate is set again.
- R4: A rising edge on `nmi_in` sets `nmi_req` three clock edges after the change, whatever the gate says. `nmi_ack` clears it. While the gate is 0, `nmi_req` never raises `wake`.
- R5: With bit 6 = 0, a rising edge on `spi_evt & spi_en` sets `src_req[0]` on the third clock edge (gate on). The request stays set after the input falls, until `src_ack[0]`.
- R6: With bit 6 = 1, `src_req[0]` follows `spi_evt & spi_en` delayed by two clock edges. Edges seen in this mode latch nothing.
- R7: Port pin i feeds source 2 (`src_req[1]`) only when both `pin_opt[i]` and `pin_dat[i]` are 1. With bit 5 = 1 a rising pin edge is taken, and with bit 5 = 0 a falling edge is taken. The request is latched three edges later.
- R8: `src_req[2]` is the OR of `tmr_ovf&tmr_en`, `art_ovf&art_ovf_en` and `art_cmp&art_cmp_en`, gated by bit 4. It has no register on the path.
- R9: `src_req[3]` is the OR of `adc_eoc&adc_en`, `urx&urx_en` and `utx&utx_en`, gated by bit 4. It has no register on the path.
- R10: A pulse on `src_ack[0]`, `src_ack[1]` or `nmi_ack` clears the matching pending latch on that clock edge.
- R11: Changing the option register does not clear a pending latch.
- R12: `wake` is high exactly when some `src_req` bit is high, or when `nmi_req` is high and bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| nmi_in | input | 1 | Raw non-maskable request |
| nmi_ack | input | 1 | Acknowledge pulse for the non-maskable request |
| spi_evt | input | 1 | Serial transfer-done event (source 1) |
| spi_en | input | 1 | Enable for `spi_evt` |
| pin_in | input | 24 | Port pin levels (source 2) |
| pin_opt | input | 24 | Per-pin option bit |
| pin_dat | input | 24 | Per-pin data bit |
| tmr_ovf | input | 1 | Timer overflow flag |
| tmr_en | input | 1 | Enable for `tmr_ovf` |
| art_ovf | input | 1 | Auto-reload timer overflow flag |
| art_ovf_en | input | 1 | Enable for `art_ovf` |
| art_cmp | input | 1 | Auto-reload timer compare flag |
| art_cmp_en | input | 1 | Enable for `art_cmp` |
| adc_eoc | input | 1 | Conversion-done flag |
| adc_en | input | 1 | Enable for `adc_eoc` |
| urx | input | 1 | UART byte-received flag |
| urx_en | input | 1 | Enable for `urx` |
| utx | input | 1 | UART byte-sent flag |
| utx_en | input | 1 | Enable for `utx` |
| src_ack | input | 4 | Per-source acknowledge pulses; bits 3..2 have no effect |
| src_req | output | 4 | Gated requests, bit 0 = source 1 |
| nmi_req | output | 1 | Non-maskable request |
| wake | output | 1 | Wake-up from stop/wait |

## Verification
The latch assertions take it for granted that an acknowledge pulse and a new edge of the same source do not arrive in the same cycle. If they do, the set wins and the clear property does not apply. The bench therefore sends each acknowledge only after the input it answers has settled. The bench changes the active edge of source 2 only while no pin that drives it is enabled, because such a change seen through an enabled pin would look like a fresh edge. All stimulus is driven on the falling clock edge, so every synchronizer samples a stable value.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int NSRC    = 4;
  localparam int LES_POS = 6;
  localparam int ESB_POS = 5;
  localparam int GEN_POS = 4;

  typedef struct packed {
    logic les;   // source 1 level mode
    logic esb;   // source 2 rising edge
    logic gen;   // global gate
  } irq_opt_t;
endpackage

// File: rtl/irq_opt_reg.sv
module irq_opt_reg
  import irq_cond_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR = 8'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output irq_opt_t          opt
);
  localparam logic [DATA_W-1:0] USED =
    (DATA_W'(1) << LES_POS) | (DATA_W'(1) << ESB_POS) | (DATA_W'(1) << GEN_POS);

  logic hit;
  logic unused_data;

  assign hit         = wr_en && (wr_addr == ADDR);
  assign unused_data = ^(wr_data & ~USED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt <= '0;
    else if (hit) opt <= '{les: wr_data[LES_POS], esb: wr_data[ESB_POS], gen: wr_data[GEN_POS]};
  end

  AST_OPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !hit |=> $stable(opt)); // R2
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic arm,
  input  logic ack,
  output logic lvl,
  output logic pend
);
  logic [SYNC_STAGES-1:0] sh;
  logic prev;
  logic set;

  assign lvl = sh[SYNC_STAGES-1];
  assign set = arm & lvl & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_STAGES-2:0], din};
      prev <= lvl;
      pend <= set | (pend & ~ack);
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack && !set) |=> !pend); // R10
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (pend && !ack) |=> pend); // R5
endmodule

// File: rtl/irq_pin_merge.sv
module irq_pin_merge #(
  parameter int NPIN = 24
) (
  input  logic [NPIN-1:0] pin,
  input  logic [NPIN-1:0] pin_opt,
  input  logic [NPIN-1:0] pin_dat,
  input  logic            rise_pol,
  output logic            merged
);
  logic [NPIN-1:0] act;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign act[i] = pin_opt[i] & pin_dat[i] & ~(pin[i] ^ rise_pol);
  end

  assign merged = |act;
endmodule

// File: rtl/irq_cond_top.sv
module irq_cond_top
  import irq_cond_pkg::*;
#(
  parameter int NPORT       = 3,
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 8'hC8,
  parameter int SYNC_STAGES = 2,
  localparam int NPIN       = NPORT * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              nmi_in,
  input  logic              nmi_ack,
  input  logic              spi_evt,
  input  logic              spi_en,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [NPIN-1:0]   pin_opt,
  input  logic [NPIN-1:0]   pin_dat,
  input  logic              tmr_ovf,
  input  logic              tmr_en,
  input  logic              art_ovf,
  input  logic              art_ovf_en,
  input  logic              art_cmp,
  input  logic              art_cmp_en,
  input  logic              adc_eoc,
  input  logic              adc_en,
  input  logic              urx,
  input  logic              urx_en,
  input  logic              utx,
  input  logic              utx_en,
  input  logic [NSRC-1:0]   src_ack,
  output logic [NSRC-1:0]   src_req,
  output logic              nmi_req,
  output logic              wake
);
  irq_opt_t        opt;
  logic            s1_lvl, s1_pend;
  logic            s2_in, s2_pend;
  logic            s3_raw, s4_raw;
  logic [NSRC-1:0] src_pre;
  logic            unused_lvl_s2, unused_lvl_nmi, unused_ack;

  assign unused_ack = ^src_ack[NSRC-1:2];

  irq_opt_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR(OPT_ADDR)) u_opt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .opt(opt)
  );

  irq_edge_pend #(.SYNC_STAGES(SYNC_STAGES)) u_s1 (
    .clk(clk), .rst_n(rst_n), .din(spi_evt & spi_en), .arm(~opt.les),
    .ack(src_ack[0]), .lvl(s1_lvl), .pend(s1_pend)
  );

  irq_pin_merge #(.NPIN(NPIN)) u_pins (
    .pin(pin_in), .pin_opt(pin_opt), .pin_dat(pin_dat), .rise_pol(opt.esb), .merged(s2_in)
  );

  irq_edge_pend #(.SYNC_STAGES(SYNC_STAGES)) u_s2 (
    .clk(clk), .rst_n(rst_n), .din(s2_in), .arm(1'b1),
    .ack(src_ack[1]), .lvl(unused_lvl_s2), .pend(s2_pend)
  );

  irq_edge_pend #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst_n(rst_n), .din(nmi_in), .arm(1'b1),
    .ack(nmi_ack), .lvl(unused_lvl_nmi), .pend(nmi_req)
  );

  assign s3_raw  = (tmr_ovf & tmr_en) | (art_ovf & art_ovf_en) | (art_cmp & art_cmp_en);
  assign s4_raw  = (adc_eoc & adc_en) | (urx & urx_en) | (utx & utx_en);
  assign src_pre = {s4_raw, s3_raw, s2_pend, s1_pend | (opt.les & s1_lvl)};
  assign src_req = opt.gen ? src_pre : '0;
  assign wake    = opt.gen & ((|src_pre) | nmi_req);

  AST_GATED_OFF:   assert property (@(posedge clk) disable iff (!rst_n) !opt.gen |-> (src_req == '0)); // R3
  AST_NMI_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (nmi_req && !opt.gen) |-> !wake); // R4
  AST_WAKE_SRC:    assert property (@(posedge clk) disable iff (!rst_n) (|src_req) |-> wake); // R12
endmodule

// File: tb/irq_cond_top_tb_top.sv
`timescale 1ns/1ps
module irq_cond_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic nmi_in = 0, nmi_ack = 0, spi_evt = 0, spi_en = 0;
  logic [23:0] pin_in = '0, pin_opt = '0, pin_dat = '0;
  logic tmr_ovf = 0, tmr_en = 0, art_ovf = 0, art_ovf_en = 0, art_cmp = 0, art_cmp_en = 0;
  logic adc_eoc = 0, adc_en = 0, urx = 0, urx_en = 0, utx = 0, utx_en = 0;
  logic [3:0] src_ack = '0;
  logic [3:0] src_req;
  logic nmi_req, wake;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_cond_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .nmi_in(nmi_in), .nmi_ack(nmi_ack), .spi_evt(spi_evt), .spi_en(spi_en),
    .pin_in(pin_in), .pin_opt(pin_opt), .pin_dat(pin_dat),
    .tmr_ovf(tmr_ovf), .tmr_en(tmr_en), .art_ovf(art_ovf), .art_ovf_en(art_ovf_en),
    .art_cmp(art_cmp), .art_cmp_en(art_cmp_en), .adc_eoc(adc_eoc), .adc_en(adc_en),
    .urx(urx), .urx_en(urx_en), .utx(utx), .utx_en(utx_en),
    .src_ack(src_ack), .src_req(src_req), .nmi_req(nmi_req), .wake(wake)
  );

  // {gen, tmr,tmr_en, aovf,en, acmp,en, adc,en, rx,en, tx,en, exp_s3, exp_s4}
  localparam logic [14:0] VEC [8] = '{
    15'b1_11_00_00_00_00_00_10,
    15'b1_10_00_00_00_00_00_00,
    15'b1_00_11_00_00_00_00_10,
    15'b1_00_00_11_00_00_00_10,
    15'b1_00_00_00_11_00_00_01,
    15'b1_00_00_00_00_10_11_01,
    15'b0_11_11_11_11_11_11_00,
    15'b1_00_00_10_00_11_00_01
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_opt(input logic [7:0] d, input logic [7:0] a = 8'hC8);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 src_req", src_req, 0);
    chk("R1 nmi_req", nmi_req, 0);
    chk("R1 wake", wake, 0);

    // R2: address decode and unused bits
    tmr_ovf = 1; tmr_en = 1;
    wr_opt(8'h10, 8'hC9);
    chk("R2 wrong address", src_req, 0);
    wr_opt(8'h9F);
    chk("R2 gate bit set", src_req, 4'b0100);
    wr_opt(8'hEF);
    chk("R2 gate bit clear", src_req, 0);
    tmr_ovf = 0; tmr_en = 0;

    // R8 R9 R12: table walk
    foreach (VEC[k]) begin
      {tmr_ovf, tmr_en, art_ovf, art_ovf_en, art_cmp, art_cmp_en,
       adc_eoc, adc_en, urx, urx_en, utx, utx_en} = VEC[k][13:2];
      wr_opt(VEC[k][14] ? 8'h10 : 8'h00);
      chk("R8 source3", src_req[2], VEC[k][1]);
      chk("R9 source4", src_req[3], VEC[k][0]);
      chk("R12 wake table", wake, VEC[k][1] | VEC[k][0]);
    end
    {tmr_ovf, tmr_en, art_ovf, art_ovf_en, art_cmp, art_cmp_en,
     adc_eoc, adc_en, urx, urx_en, utx, utx_en} = '0;

    // R5 edge mode on source 1
    wr_opt(8'h10);
    spi_en = 1; spi_evt = 1;
    step(2);
    chk("R5 not yet", src_req[0], 0);
    step(1);
    chk("R5 latched", src_req[0], 1);
    spi_evt = 0;
    step(3);
    chk("R5 held after input low", src_req[0], 1);
    src_ack = 4'b0001; step(1); src_ack = '0;
    chk("R10 ack clears source1", src_req[0], 0);

    // R3 gate off keeps pending
    spi_evt = 1; step(3); spi_evt = 0;
    wr_opt(8'h00);
    chk("R3 blocked", src_req, 0);
    chk("R3 no wake", wake, 0);
    wr_opt(8'h10);
    chk("R3 pending kept", src_req[0], 1);

    // R11 mode change keeps pending
    wr_opt(8'h50);
    chk("R11 pending after mode change", src_req[0], 1);
    src_ack = 4'b0001; step(1); src_ack = '0;
    chk("R10 ack in level mode", src_req[0], 0);

    // R6 level mode
    spi_evt = 1;
    step(1);
    chk("R6 one edge", src_req[0], 0);
    step(1);
    chk("R6 follows level", src_req[0], 1);
    spi_evt = 0;
    step(2);
    chk("R6 no latch", src_req[0], 0);
    spi_en = 0; spi_evt = 1;
    step(3);
    chk("R6 masked", src_req[0], 0);
    spi_evt = 0;

    // R7 port pins, rising
    wr_opt(8'h30);
    pin_opt[5] = 1; pin_dat[5] = 1; pin_opt[9] = 1;
    pin_in[9] = 1; step(3);
    chk("R7 pin disabled", src_req[1], 0);
    pin_in[5] = 1; step(3);
    chk("R7 rising taken", src_req[1], 1);
    src_ack = 4'b0010; step(1); src_ack = '0;
    chk("R10 ack clears source2", src_req[1], 0);
    pin_in[5] = 0; step(3);
    chk("R7 falling ignored in rising mode", src_req[1], 0);
    // R7 falling
    pin_opt[5] = 0;
    wr_opt(8'h10);
    pin_in[5] = 1; step(3);
    pin_opt[5] = 1; step(3);
    chk("R7 idle in falling mode", src_req[1], 0);
    pin_in[5] = 0; step(3);
    chk("R7 falling taken", src_req[1], 1);
    src_ack = 4'b0010; step(1); src_ack = '0;
    step(3);
    chk("R7 stays clear", src_req[1], 0);

    // R4 NMI
    wr_opt(8'h00);
    nmi_in = 1; step(3);
    chk("R4 nmi with gate off", nmi_req, 1);
    chk("R4 no wake", wake, 0);
    wr_opt(8'h10);
    chk("R12 nmi wakes with gate", wake, 1);
    nmi_ack = 1; step(1); nmi_ack = 0;
    chk("R10 nmi ack", nmi_req, 0);
    chk("R12 wake drops", wake, 0);
    nmi_in = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule